// File: doc/BRIEF.md
# Multi-Duty PWM Timer Group

This block is a small timer group that produces several pulse-width-modulated outputs sharing one period. A single period counter counts down from its compare value, raises a period interrupt when it expires and reloads itself, running continuously. Each duty counter is a retriggerable one-shot. The period interrupt starts it. It holds its output high for as many count-clock cycles as its own compare value, then raises a duty interrupt and parks until the next period interrupt.

Software programs the compare values through a byte-wide write port into staging registers. Staged values reach the counters only at a period boundary, so a new period or duty never tears a waveform. All counting advances only on cycles where the count-clock enable is high. A level run input starts and stops the group, and an 8-bit mode restricts every compare value to its low byte. The period is (P + 1) count cycles and the duty of output i is Di / (P + 1), where P is the period compare value and Di is the compare value of duty channel i.

Top module: `mpwm_group`

## Requirements
- R1: While running, `irq_period` pulses once every P + 1 enabled count cycles, where P is the period channel's compare value.
- R2: After a period interrupt, `pwm_out[i]` goes high on the next enabled count cycle and stays high for exactly Di enabled count cycles when 1 <= Di <= P.
- R3: The enabled count cycle that ends a duty pulse also raises a one-clock `irq_duty[i]`, with `pwm_out[i]` already low. The channel then stays low and silent until the next period interrupt.
- R4: When Di >= P + 1, the duty counter is retriggered before it expires, so `pwm_out[i]` stays high across the whole period and `irq_duty[i]` never fires.
- R5: When Di = 0, `pwm_out[i]` never goes high, not even for one cycle, and `irq_duty[i]` still fires on the first enabled count cycle after the period interrupt.
- R6: Compare writes reach the counters only at a period interrupt (and at start). All bytes of every channel are captured together at that instant, so the period in progress keeps its old values.
- R7: When `byte_mode` is 1, only the low byte of each compare value is used, and the high bytes are taken as 00h whatever was written.
- R8: While `run` is 0, all outputs are low and no interrupts fire. A rising `run` loads the period counter with P and leaves the duty outputs low. The first period interrupt then follows after P + 1 enabled count cycles.
- R9: Nothing advances on cycles with `cnt_en` low. Every interrupt pulse appears in the clock right after an enabled count cycle.
- R10: Byte address 2c + b selects channel c and byte b, where b = 0 is the low byte. Channel 0 is the period channel, and channels 1 to 3 drive `pwm_out[0]` to `pwm_out[2]`.
- R11: While `rst_n` is low, all outputs are low and every compare register resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-clock enable, one count cycle per high clock |
| run | input | 1 | Level start/stop for the whole group |
| byte_mode | input | 1 | Use only the low byte of each compare value |
| wr_en | input | 1 | Compare-register byte write strobe |
| wr_addr | input | 3 | Byte address: channel times 2 plus byte index |
| wr_data | input | 8 | Byte write data |
| pwm_out | output | 3 | Duty outputs, one per duty channel |
| irq_period | output | 1 | Period interrupt pulse |
| irq_duty | output | 3 | Duty-end interrupt pulses |

## Verification
The bench measures each period window in enabled count cycles and compares high time and duty interrupts with values it derives from its own copy of the staged bytes. It targets duty zero, where a design that loaded and then decremented would emit a one-cycle glitch. It also targets duty equal to P and P + 1, where an off-by-one would either drop the interrupt that coincides with the period boundary or briefly pull the output low before the retrigger. Writes landing mid-period, sparse count enables and 8-bit mode with junk high bytes expose a design that loads compare values early, counts on disabled cycles or keeps the high byte.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        DUTY_PARKED   = 1'b0,
        DUTY_COUNTING = 1'b1
    } duty_mode_e;
endpackage

// File: rtl/mpwm_regfile.sv
module mpwm_regfile #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [mpwm_pkg::BYTE_W-1:0]       wr_data,
    input  logic                              byte_mode,
    input  logic                              capture,
    output logic [CNT_W-1:0]                  period_stg,
    output logic [NUM_CH-2:0][CNT_W-1:0]      duty_work
);
    localparam int BW     = mpwm_pkg::BYTE_W;
    localparam int NBYTES = CNT_W / BW;

    typedef struct packed {
        logic [NUM_CH-1:0][CNT_W-1:0] stg;
        logic [NUM_CH-2:0][CNT_W-1:0] work;
    } rf_state_t;

    rf_state_t q, d;
    logic [NUM_CH-1:0][CNT_W-1:0] eff;

    // Effective compare values; 8-bit mode drops every byte above the lowest.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            eff[c] = byte_mode ? CNT_W'(q.stg[c][BW-1:0]) : q.stg[c];
        end
    end

    always_comb begin
        d = q;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_en && (wr_addr == ADDR_W'(c * NBYTES + b))) begin
                    d.stg[c][b*BW +: BW] = wr_data;
                end
            end
        end
        if (capture) begin
            for (int s = 0; s < NUM_CH - 1; s++) begin
                d.work[s] = eff[s+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign period_stg = eff[0];
    assign duty_work  = q.work;
endmodule

// File: rtl/mpwm_period_ctr.sv
module mpwm_period_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } per_state_t;

    per_state_t q, d;

    assign expire = active && cnt_en && (q.cnt == '0);

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (start) begin
            d.cnt = reload_val;
        end else if (expire) begin
            d.cnt = reload_val;
            d.irq = 1'b1;
        end else if (active && cnt_en) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign irq = q.irq;
endmodule

// File: rtl/mpwm_duty_ctr.sv
module mpwm_duty_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             cnt_en,
    input  logic             trig,
    input  logic [CNT_W-1:0] load_val,
    output logic             pwm,
    output logic             irq
);
    import mpwm_pkg::*;

    typedef struct packed {
        duty_mode_e       mode;
        logic [CNT_W-1:0] cnt;
        logic             pwm;
        logic             irq;
    } duty_state_t;

    duty_state_t q, d;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (!active) begin
            d.pwm = 1'b0;
            if (start) begin
                d.mode = DUTY_PARKED;
                d.cnt  = '1;
            end
        end else if (cnt_en) begin
            if (trig) begin
                // Retrigger wins over expiry: a long duty never ends early.
                if (load_val == '0) begin
                    d.mode = DUTY_PARKED;
                    d.cnt  = '1;
                    d.pwm  = 1'b0;
                    d.irq  = 1'b1;
                end else begin
                    d.mode = DUTY_COUNTING;
                    d.cnt  = load_val;
                    d.pwm  = 1'b1;
                end
            end else if (q.mode == DUTY_COUNTING) begin
                if (q.cnt == CNT_W'(1)) begin
                    d.mode = DUTY_PARKED;
                    d.cnt  = '1;
                    d.pwm  = 1'b0;
                    d.irq  = 1'b1;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= DUTY_PARKED;
            q.cnt  <= '1;
        end else begin
            q <= d;
        end
    end

    assign pwm = q.pwm;
    assign irq = q.irq;
endmodule

// File: rtl/mpwm_group.sv
module mpwm_group #(
    parameter  int NUM_SLAVES = 3,
    parameter  int CNT_W      = 16,
    localparam int NUM_CH     = NUM_SLAVES + 1,
    localparam int NBYTES     = CNT_W / mpwm_pkg::BYTE_W,
    localparam int ADDR_W     = $clog2(NUM_CH * NBYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_en,
    input  logic                        run,
    input  logic                        byte_mode,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [mpwm_pkg::BYTE_W-1:0] wr_data,
    output logic [NUM_SLAVES-1:0]       pwm_out,
    output logic                        irq_period,
    output logic [NUM_SLAVES-1:0]       irq_duty
);
    typedef struct packed {
        logic run_q;
        logic trig_pend;
    } top_state_t;

    top_state_t q, d;

    logic                            start;
    logic                            active;
    logic                            expire;
    logic [CNT_W-1:0]                period_stg;
    logic [NUM_SLAVES-1:0][CNT_W-1:0] duty_work;

    assign start  = run && !q.run_q;
    assign active = run && q.run_q;

    // The duty trigger is held one count cycle after the period expiry.
    always_comb begin
        d       = q;
        d.run_q = run;
        if (!active) begin
            d.trig_pend = 1'b0;
        end else if (cnt_en) begin
            d.trig_pend = expire;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    mpwm_regfile #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .byte_mode  (byte_mode),
        .capture    (start || expire),
        .period_stg (period_stg),
        .duty_work  (duty_work)
    );

    mpwm_period_ctr #(
        .CNT_W (CNT_W)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .active     (active),
        .cnt_en     (cnt_en),
        .reload_val (period_stg),
        .expire     (expire),
        .irq        (irq_period)
    );

    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_duty
        mpwm_duty_ctr #(
            .CNT_W (CNT_W)
        ) u_duty (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (start),
            .active   (active),
            .cnt_en   (cnt_en),
            .trig     (q.trig_pend),
            .load_val (duty_work[s]),
            .pwm      (pwm_out[s]),
            .irq      (irq_duty[s])
        );
    end
endmodule

// File: rtl/mpwm_group_chk.sv
module mpwm_group_chk #(
    parameter int NUM_SLAVES = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic                  cnt_en,
    input logic                  irq_period,
    input logic [NUM_SLAVES-1:0] pwm_out,
    input logic [NUM_SLAVES-1:0] irq_duty
);
    AST_PERIOD_IRQ_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_period |-> ($past(cnt_en) && $past(run))); // R9

    AST_DUTY_IRQ_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_duty != '0) |-> $past(cnt_en)); // R9

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (pwm_out == '0 && !irq_period && irq_duty == '0)); // R8

    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_chan
        AST_FALL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(pwm_out[i]) && $past(run)) |-> irq_duty[i]); // R3

        AST_IRQ_OUTPUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            irq_duty[i] |-> !pwm_out[i]); // R3

        AST_RISE_ON_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[i]) |-> ($past(cnt_en) && $past(run))); // R2
    end
endmodule

bind mpwm_group mpwm_group_chk #(.NUM_SLAVES(NUM_SLAVES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cnt_en     (cnt_en),
    .irq_period (irq_period),
    .pwm_out    (pwm_out),
    .irq_duty   (irq_duty)
);

// File: tb/mpwm_group_test.sv
module mpwm_group_test;
    localparam int NS  = 3;
    localparam int W   = 16;
    localparam int NCH = NS + 1;
    localparam int NB  = 2;
    localparam int AW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0;
    logic          run = 1'b0;
    logic          byte_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NS-1:0] pwm_out;
    logic          irq_period;
    logic [NS-1:0] irq_duty;

    mpwm_group #(.NUM_SLAVES(NS), .CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(run),
        .byte_mode(byte_mode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .irq_period(irq_period),
        .irq_duty(irq_duty)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    dens = 100;
    int    n_ticks = 0;
    string tag_extra = "";
    bit    done = 1'b0;

    logic [7:0] stg     [NCH*NB];
    logic [7:0] stg_old [NCH*NB];
    logic       run_seen = 1'b0;
    logic       run_prev = 1'b0;
    logic       en_seen = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Mirror of the staged bytes; stg_old is the copy before the last edge's write.
    always @(posedge clk) begin
        stg_old <= stg;
        if (!rst_n) begin
            for (int k = 0; k < NCH*NB; k++) stg[k] <= 8'h00;
        end else if (wr_en) begin
            stg[wr_addr] <= wr_data;
        end
        run_prev <= run_seen;
        run_seen <= run;
        en_seen  <= cnt_en;
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) cnt_en <= ($urandom_range(99) < dens);

    function automatic int eff_val(int c);
        if (byte_mode) return int'(stg_old[c*NB]);
        return int'({stg_old[c*NB+1], stg_old[c*NB]});
    endfunction

    function automatic string mods();
        string s;
        s = tag_extra;
        if (byte_mode) s = {s, " R7 R10"};
        if (dens < 100) s = {s, " R9"};
        return s;
    endfunction

    int edges;
    int high [NS];
    int sirq [NS];
    int exp_m;
    int exp_s [NS];
    bit first;

    task automatic capture();
        exp_m = eff_val(0);
        for (int i = 0; i < NS; i++) exp_s[i] = eff_val(i + 1);
        edges = 0;
        for (int i = 0; i < NS; i++) begin high[i] = 0; sirq[i] = 0; end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (run_seen && !run_prev) begin
                capture();
                first = 1'b1;
            end else if (run_seen && run_prev) begin
                if (en_seen) begin
                    edges++;
                    for (int i = 0; i < NS; i++) if (pwm_out[i]) high[i]++;
                end
                for (int i = 0; i < NS; i++) if (irq_duty[i]) sirq[i]++;
                if (irq_period) begin
                    n_ticks++;
                    chk(en_seen == 1'b1, {"R9 period irq after enabled cycle", mods()}, int'(en_seen), 1);
                    if (first) begin
                        chk(edges == exp_m + 1, {"R8 first tick delay", mods()}, edges, exp_m + 1);
                        for (int i = 0; i < NS; i++) begin
                            chk(high[i] == 0 && sirq[i] == 0, {"R8 duty idle before first tick", mods()},
                                high[i] + sirq[i], 0);
                        end
                    end else begin
                        chk(edges == exp_m + 1, {"R1 period length", mods()}, edges, exp_m + 1);
                        for (int i = 0; i < NS; i++) begin
                            int eh;
                            int ei;
                            string t;
                            eh = (exp_s[i] < exp_m + 1) ? exp_s[i] : exp_m + 1;
                            ei = (exp_s[i] <= exp_m) ? 1 : 0;
                            t  = (exp_s[i] == 0) ? "R5" : ((exp_s[i] > exp_m) ? "R4" : "R2");
                            chk(high[i] == eh, {t, " high time", mods()}, high[i], eh);
                            chk(sirq[i] == ei, {"R3 duty irq count", mods()}, sirq[i], ei);
                        end
                    end
                    capture();
                    first = 1'b0;
                end
            end
        end
    end

    task automatic wr_reg(int a, logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ch(int c, int v);
        wr_reg(c*NB, v[7:0]);
        wr_reg(c*NB + 1, v[15:8]);
    endtask

    task automatic wait_ticks(int n);
        int t0;
        t0 = n_ticks;
        while (n_ticks < t0 + n) @(negedge clk);
    endtask

    task automatic run_case(int m, int s0, int s1, int s2, bit bm, int d, int nper);
        @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        byte_mode = bm;
        dens = d;
        set_ch(0, m);
        set_ch(1, s0);
        set_ch(2, s1);
        set_ch(3, s2);
        @(negedge clk);
        run = 1'b1;
        wait_ticks(nper);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R11: outputs low in reset
        chk(pwm_out == '0 && !irq_period && irq_duty == '0, "R11 reset outputs",
            int'({pwm_out, irq_period, irq_duty}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pwm_out == '0 && !irq_period && irq_duty == '0, "R11 outputs after reset",
            int'({pwm_out, irq_period, irq_duty}), 0);

        // Directed: duty 3, zero, P+1 and P against P = 9
        run_case(9, 3, 0, 10, 1'b0, 100, 4);
        run_case(9, 9, 12, 1, 1'b0, 100, 4);
        // Period of one count cycle
        run_case(0, 0, 1, 5, 1'b0, 100, 5);
        // R10: distinct values per channel address
        tag_extra = " R10";
        run_case(7, 1, 4, 6, 1'b0, 100, 4);
        // R7: junk high bytes in 8-bit mode
        tag_extra = " R7";
        run_case(16'hA50B, 16'h5A0C, 16'h0005, 16'hFF00, 1'b1, 100, 4);
        // R9: sparse count enable
        tag_extra = "";
        run_case(6, 2, 6, 0, 1'b0, 35, 4);

        // R6: rewrite all values mid-period
        run_case(9, 3, 4, 5, 1'b0, 100, 2);
        repeat (4) @(negedge clk);
        tag_extra = " R6";
        set_ch(0, 6);
        set_ch(1, 2);
        set_ch(2, 8);
        set_ch(3, 0);
        wait_ticks(3);
        tag_extra = "";

        // R8: stop keeps outputs low and silent
        @(negedge clk);
        run = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(pwm_out == '0 && !irq_period && irq_duty == '0, "R8 stopped outputs quiet",
                int'({pwm_out, irq_period, irq_duty}), 0);
        end

        // Constrained random cases with mid-run rewrites
        for (int k = 0; k < 30; k++) begin
            int m;
            int s [NS];
            bit bm;
            int d;
            bm = 1'($urandom_range(1));
            m  = $urandom_range(24);
            for (int i = 0; i < NS; i++) s[i] = $urandom_range(m + 3);
            if (bm) begin
                m = m + ($urandom_range(255) << 8);
                for (int i = 0; i < NS; i++) s[i] = s[i] + ($urandom_range(255) << 8);
            end
            d = ($urandom_range(1) == 1) ? 100 : 30 + $urandom_range(50);
            run_case(m, s[0], s[1], s[2], bm, d, 2);
            repeat ($urandom_range(6)) @(negedge clk);
            tag_extra = " R6";
            set_ch($urandom_range(NS), $urandom_range(20));
            wait_ticks(3);
            tag_extra = "";
        end

        @(negedge clk);
        run = 1'b0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule